// File: doc/BRIEF.md
# Cascaded Delay Chain Controller

This block strings a parameterised number of digitally programmable delay stages end to end so that one serial input bit stream can be retarded by far more steps than a single stage provides. Each stage is a clocked tap line whose length is a fixed two-cycle cost plus a selectable number of extra cycles. One unit step is one clock cycle.

A wide address bus programs the whole chain. The low select bits set the tap count of the first stage. Each further address bit is a cascade flag for the next stage. A later stage never sees select data. It only knows whether its predecessor asks it to sit at its shortest setting or at its longest setting, and it follows that flag with no glue logic between the stages.

A single load-enable controls all configuration bits together. While it is low, the bus is captured on every rising clock edge. While it is high, the captured word is frozen, so the select word and the override pattern always change on the same edge.

Top module: `dly_cascade`

## Requirements
- R1: Synchronous active-high reset drives `dout` to 0 and clears the captured configuration. With no load after reset, the input-to-output latency is the fixed minimum of 2 cycles per stage.
- R2: With `load_en` low, `addr` is captured on each rising clock edge, and the last captured word wins. With `load_en` high, later changes on `addr` have no effect on the delay.
- R3: Address bits [SEL_W-1:0] (bits 0..9 by default) add exactly that unsigned number of cycles through the first stage.
- R4: The cascade flag for stage k+1 (counting the first stage as stage 0) is address bit SEL_W+k: bit 10 steers the second stage and bit 11 steers the third. The bus is SEL_W+N_STAGES-1 bits wide, and the last stage drives no cascade flag.
- R5: A stage whose predecessor flag is low is forced to its minimum and adds 0 steps. A stage whose predecessor flag is high is forced to its maximum and adds 2^SEL_W (1024) steps.
- R6: A stage forced to its minimum emits a low cascade flag whatever its own address bit holds. A stage forced to its maximum passes its own bit on. The added steps are therefore 1024 times the run of ones starting at bit 10.
- R7: Total latency equals 2*N_STAGES plus the programmed step count. Two stages span 4 to 2051 cycles, with all-ones low bits and bit 10 set giving 1024+1023 steps.
- R8: The output reproduces the input waveform unchanged: a one-cycle pulse leaves as a one-cycle pulse, and a multi-bit pattern leaves in order. Tap history not yet written since reset reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one delay step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Low: capture `addr` each edge; high: hold captured word |
| addr | input | SEL_W+N_STAGES-1 (11) | Select word in low bits, one cascade flag per extra stage above |
| din | input | 1 | Serial data to be delayed |
| dout | output | 1 | Delayed data, registered |

## Verification
A corrupted captured word or a broken override decode shows up at `dout` as a pulse that arrives early or late. An error in a cascade flag moves the pulse by a multiple of 1024 cycles, while a select-bit error moves it by that bit's weight. A fault in the tap-line read pointer or history gating appears as a widened, split or spurious pulse within one traversal of the programmed latency. Each scenario therefore times a single pulse, or a short pattern, from input to output and compares the arrival cycle and the shape against the latency formula.

// File: rtl/dlyc_pkg.sv
package dlyc_pkg;

  // Fixed per-stage latency in cycles: tap write plus registered read.
  localparam int STAGE_FIXED_LAT = 2;

  // How a stage's tap count is chosen.
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,  // select word decides
    OVR_MIN  = 2'd1,  // pinned to zero extra steps
    OVR_MAX  = 2'd2   // pinned to full range
  } ovr_mode_e;

endpackage

// File: rtl/dlyc_cfg_latch.sv
module dlyc_cfg_latch #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Open while load_en is low, frozen while high; cleared by reset.
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (!load_en)
      q <= d;
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> $stable(q)); // R2

  AST_OPEN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (q == $past(d))); // R2

endmodule

// File: rtl/dlyc_stage_ctrl.sv
module dlyc_stage_ctrl
  import dlyc_pkg::*;
#(
  parameter int SEL_W = 10
) (
  input  ovr_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             own_casc,
  output logic [SEL_W:0]   steps,
  output logic             casc_out
);

  localparam logic [SEL_W:0] FULL_STEPS = (SEL_W+1)'(1) << SEL_W;

  always_comb begin
    unique case (mode)
      OVR_MIN: steps = '0;
      OVR_MAX: steps = FULL_STEPS;
      default: steps = {1'b0, sel};
    endcase
  end

  // A stage pinned to minimum stops the chain from growing further.
  assign casc_out = own_casc & (mode != OVR_MIN);

endmodule

// File: rtl/dlyc_tap_line.sv
module dlyc_tap_line #(
  parameter int SEL_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           din,
  input  logic [SEL_W:0] steps,
  output logic           dout
);

  localparam int AW    = SEL_W + 1;
  localparam int DEPTH = 1 << AW;

  logic          mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [AW:0]   fill;
  logic [AW:0]   need;
  logic          hist_ok;

  // Entry read this edge was written (steps + 1) edges ago.
  assign rd_addr = wr_ptr - steps - AW'(1);
  assign need    = {1'b0, steps} + (AW+1)'(1);
  assign hist_ok = (fill >= need);

  // History store: no reset, single write port, registered read.
  always_ff @(posedge clk) begin
    mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      fill   <= '0;
      dout   <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + AW'(1);
      if (fill != (AW+1)'(DEPTH))
        fill <= fill + (AW+1)'(1);
      dout <= hist_ok ? mem[rd_addr] : 1'b0;
    end
  end

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    steps <= ((AW)'(1) << SEL_W)); // R5

endmodule

// File: rtl/dly_cascade.sv
module dly_cascade
  import dlyc_pkg::*;
#(
  parameter  int N_STAGES = 2,
  parameter  int SEL_W    = 10,
  localparam int ADDR_W   = SEL_W + N_STAGES - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout
);

  localparam logic [SEL_W:0] FULL_STEPS = (SEL_W+1)'(1) << SEL_W;

  logic                          din_q;
  logic [ADDR_W-1:0]             cfg_q;
  logic [N_STAGES-1:0]           casc_out;
  logic [N_STAGES-1:0][SEL_W:0]  steps_all;
  logic [N_STAGES:0]             tap;

  always_ff @(posedge clk) begin
    if (rst)
      din_q <= 1'b0;
    else
      din_q <= din;
  end

  // One capture register for every configuration bit: all stages switch together.
  dlyc_cfg_latch #(.W(ADDR_W)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .d       (addr),
    .q       (cfg_q)
  );

  assign tap[0] = din_q;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    ovr_mode_e        mode;
    logic [SEL_W-1:0] sel;
    logic             own;

    if (i == 0) begin : g_head
      assign mode = OVR_NONE;
      assign sel  = cfg_q[SEL_W-1:0];
    end else begin : g_tail
      assign mode = casc_out[i-1] ? OVR_MAX : OVR_MIN;
      assign sel  = '0;
    end

    if (i < N_STAGES - 1) begin : g_flag
      assign own = cfg_q[SEL_W+i];
    end else begin : g_noflag
      assign own = 1'b0;
    end

    dlyc_stage_ctrl #(.SEL_W(SEL_W)) ctrl_i (
      .mode     (mode),
      .sel      (sel),
      .own_casc (own),
      .steps    (steps_all[i]),
      .casc_out (casc_out[i])
    );

    dlyc_tap_line #(.SEL_W(SEL_W)) line_i (
      .clk   (clk),
      .rst   (rst),
      .din   (tap[i]),
      .steps (steps_all[i]),
      .dout  (tap[i+1])
    );

    if (i > 0) begin : g_chk
      AST_MAX_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
        casc_out[i-1] |-> (steps_all[i] == FULL_STEPS)); // R5

      AST_MIN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !casc_out[i-1] |-> ((steps_all[i] == '0) && !casc_out[i])); // R6
    end
  end

  assign dout = tap[N_STAGES];

  AST_LAST_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !casc_out[N_STAGES-1]); // R4

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !dout); // R1

endmodule

// File: tb/dly_cascade_tb_top.sv
`timescale 1ns/1ps
module dly_cascade_tb_top;

  localparam int N   = 3;
  localparam int SW  = 10;
  localparam int AW  = SW + N - 1;
  localparam int FIX = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b1;
  logic          din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          dout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dly_cascade #(.N_STAGES(N), .SEL_W(SW)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .addr    (addr),
    .din     (din),
    .dout    (dout)
  );

  task automatic check(input bit ok, input string req, input int act,
                       input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Latency from the requirements: fixed cost plus low word plus run of flags.
  function automatic int exp_lat(input logic [AW-1:0] a);
    int s;
    s = int'(a[SW-1:0]);
    for (int k = 0; k < N - 1; k++) begin
      if (!a[SW+k]) break;
      s += (1 << SW);
    end
    return FIX + s;
  endfunction

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_cfg(input logic [AW-1:0] a);
    @(negedge clk);
    addr    = a;
    load_en = 1'b0;
    @(negedge clk);
    load_en = 1'b1;
  endtask

  task automatic flush();
    din = 1'b0;
    repeat (2200) @(negedge clk);
  endtask

  task automatic measure(input int exp, input string req, input string what);
    int lat;
    lat = -1;
    @(negedge clk);
    din = 1'b1;
    for (int j = 0; j < 6000; j++) begin
      @(negedge clk);
      if (j == 0) din = 1'b0;
      if (dout) begin
        lat = j;
        break;
      end
    end
    check(lat == exp, req, lat, exp, what);
    @(negedge clk);
    check(dout == 1'b0, "R8", int'(dout), 0, "pulse width one cycle");
    flush();
  endtask

  task automatic t_reset();
    apply_reset();
    check(dout == 1'b0, "R1", int'(dout), 0, "dout after reset");
    measure(FIX, "R1", "latency with cleared config");
  endtask

  task automatic t_low_word();
    int vals[5] = '{1, 5, 255, 512, 1023};
    foreach (vals[k]) begin
      load_cfg(AW'(vals[k]));
      measure(exp_lat(AW'(vals[k])), "R3", $sformatf("low word %0d", vals[k]));
    end
  endtask

  task automatic t_one_flag();
    logic [AW-1:0] a;
    a = AW'(1 << SW);
    load_cfg(a);
    measure(FIX + 1024, "R5", "bit10 set, low word 0");
    a = AW'((1 << SW) | 1023);
    load_cfg(a);
    measure(FIX + 2047, "R7", "bit10 set, low word all ones");
  endtask

  task automatic t_flag_blocked();
    logic [AW-1:0] a;
    a = AW'((1 << (SW + 1)) | 7);
    load_cfg(a);
    measure(FIX + 7, "R6", "bit11 alone is blocked by min stage");
  endtask

  task automatic t_full_chain();
    logic [AW-1:0] a;
    a = AW'((3 << SW) | 3);
    load_cfg(a);
    measure(FIX + 2048 + 3, "R4", "bits 10 and 11 set, low word 3");
  endtask

  task automatic t_hold();
    load_cfg(AW'(20));
    @(negedge clk);
    addr = AW'(900);
    repeat (3) @(negedge clk);
    measure(FIX + 20, "R2", "addr change while locked ignored");
  endtask

  task automatic t_capture_last();
    @(negedge clk);
    addr    = AW'(100);
    load_en = 1'b0;
    @(negedge clk);
    addr = AW'(37);
    @(negedge clk);
    load_en = 1'b1;
    addr    = AW'(500);
    measure(FIX + 37, "R2", "last captured word wins");
  endtask

  task automatic t_pattern();
    logic [4:0] p;
    int         lat;
    p   = 5'b01101;
    lat = FIX + 10;
    load_cfg(AW'(10));
    @(negedge clk);
    din = p[0];
    for (int j = 0; j < lat + 5; j++) begin
      @(negedge clk);
      din = (j < 4) ? p[j+1] : 1'b0;
      if (j >= lat)
        check(dout == p[j-lat], "R8", int'(dout), int'(p[j-lat]),
              $sformatf("pattern bit %0d", j - lat));
    end
    flush();
  endtask

  initial begin
    t_reset();
    t_low_word();
    t_one_flag();
    t_flag_blocked();
    t_full_chain();
    t_hold();
    t_capture_last();
    t_pattern();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule